// File: doc/BRIEF.md
# Sound DSP Command Sequencer

This block is the device side of a legacy sound DSP. A host writes command bytes one at a time. The block decodes opcodes that take zero, two or three parameter bytes. From these commands it sets the input and output sample rates, and it starts, pauses and resumes two transfer engines, one for 8-bit samples and one for 16-bit samples.

Each engine requests one transfer unit at a time from an external DMA controller through a request/acknowledge pair. It counts the units in a block and restarts automatically when the block ends, so a programmed transfer runs until it is paused. Every block end, and every MIDI input event, sets a latched bit in an interrupt status register. The host clears each bit with its own acknowledge input.

Top module: `snd_dsp_sequencer`

## Requirements
- R1: Opcode 0x41 sets the output rate and opcode 0x42 sets the input rate. Each takes two parameter bytes, the high byte first and then the low byte. Any 16-bit value, including 4000 and 44100, is stored exactly and is visible on its rate output two cycles after the last byte is accepted.
- R2: Opcode 0xC0 starts the 8-bit engine and opcode 0xB0 starts the 16-bit engine. Each takes three parameter bytes in this order: a mode byte, the count low byte, then the count high byte. Mode bit 0 means signed samples and mode bit 1 means stereo. These two bits appear on that engine's mode output.
- R3: A block holds count+1 transfer units, where a unit is one cycle with both request and acknowledge high. On the last unit of a block the engine sets its status bit, reloads the count and keeps its request high.
- R4: Opcodes 0xD0 and 0xD4 pause and resume the 8-bit engine; 0xD5 and 0xD6 pause and resume the 16-bit engine. None of them takes a parameter. A paused engine drops its request and ignores acknowledges. After a resume it continues with the remaining units of the block. Pausing one engine does not affect the other.
- R5: Status bit 0 is set by the 8-bit engine, bit 1 by the 16-bit engine and bit 2 by a MIDI input event. A bit is cleared only by its own acknowledge input. An event in the same cycle as that bit's acknowledge leaves the bit set. The irq output is the OR of the three bits.
- R6: While parameter bytes are still expected, every byte written is taken as a parameter, even if its value is an opcode.
- R7: A byte that is not one of the opcodes listed above is discarded and takes no parameters. The next byte is decoded as an opcode.
- R8: host_busy is high for exactly the one cycle after the last byte of a command is accepted. A byte written while host_busy is high is dropped.
- R9: A start command sent to an engine that is already running does not disturb the current block. Its count and mode take effect at the next block boundary.
- R10: After reset, host_busy, both requests and all status bits are 0, and both rates are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr_valid | input | 1 | Host writes a command byte this cycle |
| host_wr_data | input | 8 | Command or parameter byte |
| host_busy | output | 1 | Byte writes are dropped while high |
| out_rate | output | 16 | Programmed output sample rate |
| in_rate | output | 16 | Programmed input sample rate |
| dma8_req | output | 1 | 8-bit engine requests a transfer unit |
| dma8_ack | input | 1 | DMA controller grants one 8-bit unit |
| dma16_req | output | 1 | 16-bit engine requests a transfer unit |
| dma16_ack | input | 1 | DMA controller grants one 16-bit unit |
| mode8 | output | 2 | 8-bit engine mode: bit 0 signed, bit 1 stereo |
| mode16 | output | 2 | 16-bit engine mode: bit 0 signed, bit 1 stereo |
| midi_rx_event | input | 1 | One-cycle MIDI receive event |
| irq_ack8 | input | 1 | Clears status bit 0 |
| irq_ack16 | input | 1 | Clears status bit 1 |
| irq_ack_midi | input | 1 | Clears status bit 2 |
| irq_status | output | 3 | Latched interrupt causes |
| irq | output | 1 | Any status bit set |

## Verification
A table of rate commands alternates between the two rate opcodes and uses the minimum and maximum required rates. This separates the two rate registers and checks the high-byte-first assembly. Start commands with asymmetric counts (3 with stereo signed mode, and 256) show whether the count bytes are taken low byte first and whether a block really holds count+1 units. Opcode-valued parameters, an unknown opcode and a byte written during the busy cycle separate the "parameter", "discard" and "drop" paths of the decoder. Pause with ignored acknowledges, a start issued mid-block, and an event that coincides with an acknowledge cover the count-preserving and ordering corner cases.

// File: rtl/snd_dsp_pkg.sv
package snd_dsp_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int ARG_W  = 3 * BYTE_W;
    localparam int NUM_IRQ = 3;

    localparam logic [7:0] OP_RATE_OUT = 8'h41;
    localparam logic [7:0] OP_RATE_IN  = 8'h42;
    localparam logic [7:0] OP_START8   = 8'hC0;
    localparam logic [7:0] OP_START16  = 8'hB0;
    localparam logic [7:0] OP_PAUSE8   = 8'hD0;
    localparam logic [7:0] OP_RESUME8  = 8'hD4;
    localparam logic [7:0] OP_PAUSE16  = 8'hD5;
    localparam logic [7:0] OP_RESUME16 = 8'hD6;

    typedef struct packed {
        logic             fire;
        logic [7:0]       op;
        logic [ARG_W-1:0] args;
    } dsp_cmd_t;

    function automatic logic op_known(input logic [7:0] op);
        return (op == OP_RATE_OUT) || (op == OP_RATE_IN) || (op == OP_START8) ||
               (op == OP_START16) || (op == OP_PAUSE8) || (op == OP_RESUME8) ||
               (op == OP_PAUSE16) || (op == OP_RESUME16);
    endfunction

    function automatic logic [1:0] op_params(input logic [7:0] op);
        if (op == OP_RATE_OUT || op == OP_RATE_IN) return 2'd2;
        if (op == OP_START8 || op == OP_START16)   return 2'd3;
        return 2'd0;
    endfunction
endpackage

// File: rtl/snd_dsp_cmd_decoder.sv
module snd_dsp_cmd_decoder
    import snd_dsp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_valid,
    input  logic [7:0] wr_data,
    output logic       busy,
    output dsp_cmd_t   cmd
);
    typedef struct packed {
        logic [1:0]       rem;
        logic [7:0]       op;
        logic [ARG_W-1:0] args;
        logic             fire;
    } dec_t;

    dec_t dec_d, dec_q;

    always_comb begin
        dec_d      = dec_q;
        dec_d.fire = 1'b0;
        if (wr_valid && !dec_q.fire) begin
            if (dec_q.rem == 2'd0) begin
                if (op_known(wr_data)) begin
                    dec_d.op   = wr_data;
                    dec_d.args = '0;
                    dec_d.rem  = op_params(wr_data);
                    dec_d.fire = (op_params(wr_data) == 2'd0);
                end
            end else begin
                dec_d.args = {dec_q.args[ARG_W-BYTE_W-1:0], wr_data};
                dec_d.rem  = dec_q.rem - 2'd1;
                dec_d.fire = (dec_q.rem == 2'd1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign busy      = dec_q.fire;
    assign cmd.fire  = dec_q.fire;
    assign cmd.op    = dec_q.op;
    assign cmd.args  = dec_q.args;

    assert_busy_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);
    assert_param_not_opcode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_q.rem != 2'd0 && wr_valid && !busy) |=> (dec_q.op == $past(dec_q.op)));
endmodule

// File: rtl/snd_dsp_xfer_engine.sv
module snd_dsp_xfer_engine
    import snd_dsp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             pause,
    input  logic             resume,
    input  logic [1:0]       mode_in,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic             dma_ack,
    output logic             dma_req,
    output logic             block_end,
    output logic [1:0]       mode_out
);
    typedef struct packed {
        logic             run;
        logic             hold;
        logic [1:0]       mode;
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] cnt;
        logic             pend;
        logic [CNT_W-1:0] pend_cnt;
        logic [1:0]       pend_mode;
    } eng_t;

    eng_t eng_d, eng_q;
    logic unit_done;

    assign dma_req   = eng_q.run && !eng_q.hold;
    assign unit_done = dma_req && dma_ack;
    assign block_end = unit_done && (eng_q.cnt == '0);
    assign mode_out  = eng_q.mode;

    always_comb begin
        eng_d = eng_q;
        if (unit_done) begin
            if (eng_q.cnt == '0) begin
                if (eng_q.pend) begin
                    eng_d.reload = eng_q.pend_cnt;
                    eng_d.cnt    = eng_q.pend_cnt;
                    eng_d.mode   = eng_q.pend_mode;
                    eng_d.pend   = 1'b0;
                end else begin
                    eng_d.cnt = eng_q.reload;
                end
            end else begin
                eng_d.cnt = eng_q.cnt - 1'b1;
            end
        end
        if (start) begin
            if (!eng_q.run) begin
                eng_d.run    = 1'b1;
                eng_d.hold   = 1'b0;
                eng_d.reload = cnt_in;
                eng_d.cnt    = cnt_in;
                eng_d.mode   = mode_in;
            end else begin
                eng_d.pend      = 1'b1;
                eng_d.pend_cnt  = cnt_in;
                eng_d.pend_mode = mode_in;
            end
        end
        if (pause && eng_q.run) eng_d.hold = 1'b1;
        if (resume)             eng_d.hold = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assert_count_kept_while_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_req && !start) |=> (eng_q.cnt == $past(eng_q.cnt)));
    assert_reload_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (block_end && !eng_q.pend && !start) |=> (eng_q.cnt == $past(eng_q.reload) && dma_req));
    assert_pending_applied_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (block_end && eng_q.pend) |=> (eng_q.cnt == $past(eng_q.pend_cnt)));
endmodule

// File: rtl/snd_dsp_irq_status.sv
module snd_dsp_irq_status
    import snd_dsp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] event_in,
    input  logic [NUM_IRQ-1:0] ack_in,
    output logic [NUM_IRQ-1:0] status,
    output logic               irq
);
    logic [NUM_IRQ-1:0] stat_d, stat_q;

    always_comb begin
        stat_d = (stat_q & ~ack_in) | event_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign status = stat_q;
    assign irq    = |stat_q;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_chk
        assert_event_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
            event_in[i] |=> status[i]);
        assert_only_own_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (status[i] && !ack_in[i]) |=> status[i]);
    end
endmodule

// File: rtl/snd_dsp_sequencer.sv
module snd_dsp_sequencer
    import snd_dsp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr_valid,
    input  logic [7:0]  host_wr_data,
    output logic        host_busy,
    output logic [15:0] out_rate,
    output logic [15:0] in_rate,
    output logic        dma8_req,
    input  logic        dma8_ack,
    output logic        dma16_req,
    input  logic        dma16_ack,
    output logic [1:0]  mode8,
    output logic [1:0]  mode16,
    input  logic        midi_rx_event,
    input  logic        irq_ack8,
    input  logic        irq_ack16,
    input  logic        irq_ack_midi,
    output logic [2:0]  irq_status,
    output logic        irq
);
    localparam int NUM_ENG = 2;

    typedef struct packed {
        logic [15:0] out_r;
        logic [15:0] in_r;
    } rate_t;

    dsp_cmd_t         cmd;
    rate_t            rate_d, rate_q;
    logic [NUM_ENG-1:0] eng_ack, eng_req, eng_end;
    logic [1:0]       eng_mode [NUM_ENG];
    logic [CNT_W-1:0] cmd_cnt;

    snd_dsp_cmd_decoder u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (host_wr_valid),
        .wr_data  (host_wr_data),
        .busy     (host_busy),
        .cmd      (cmd)
    );

    always_comb begin
        rate_d = rate_q;
        if (cmd.fire && cmd.op == OP_RATE_OUT) rate_d.out_r = cmd.args[15:0];
        if (cmd.fire && cmd.op == OP_RATE_IN)  rate_d.in_r  = cmd.args[15:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rate_q <= '0;
        else        rate_q <= rate_d;
    end

    assign out_rate = rate_q.out_r;
    assign in_rate  = rate_q.in_r;

    // args after a start command: [23:16] mode, [15:8] count low, [7:0] count high
    assign cmd_cnt = {cmd.args[7:0], cmd.args[15:8]};
    assign eng_ack = {dma16_ack, dma8_ack};

    for (genvar g = 0; g < NUM_ENG; g++) begin : g_eng
        localparam logic [7:0] OP_GO   = (g == 0) ? OP_START8  : OP_START16;
        localparam logic [7:0] OP_STOP = (g == 0) ? OP_PAUSE8  : OP_PAUSE16;
        localparam logic [7:0] OP_RES  = (g == 0) ? OP_RESUME8 : OP_RESUME16;

        snd_dsp_xfer_engine u_eng (
            .clk       (clk),
            .rst_n     (rst_n),
            .start     (cmd.fire && cmd.op == OP_GO),
            .pause     (cmd.fire && cmd.op == OP_STOP),
            .resume    (cmd.fire && cmd.op == OP_RES),
            .mode_in   (cmd.args[17:16]),
            .cnt_in    (cmd_cnt),
            .dma_ack   (eng_ack[g]),
            .dma_req   (eng_req[g]),
            .block_end (eng_end[g]),
            .mode_out  (eng_mode[g])
        );
    end

    assign dma8_req  = eng_req[0];
    assign dma16_req = eng_req[1];
    assign mode8     = eng_mode[0];
    assign mode16    = eng_mode[1];

    snd_dsp_irq_status u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .event_in ({midi_rx_event, eng_end[1], eng_end[0]}),
        .ack_in   ({irq_ack_midi, irq_ack16, irq_ack8}),
        .status   (irq_status),
        .irq      (irq)
    );

    assert_rate_out_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.fire && cmd.op == OP_RATE_OUT) |=> (out_rate == $past(cmd.args[15:0])));
    assert_rate_in_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.fire && cmd.op == OP_RATE_IN) |=> (in_rate == $past(cmd.args[15:0])));
    assert_mode_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.fire && cmd.op == OP_START8 && !dma8_req && $past(!dma8_req))
        |=> (mode8 == $past(cmd.args[17:16])));
endmodule

// File: tb/snd_dsp_sequencer_bench.sv
module snd_dsp_sequencer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_valid = 1'b0;
    logic [7:0]  host_wr_data = '0;
    logic        host_busy;
    logic [15:0] out_rate, in_rate;
    logic        dma8_req, dma16_req;
    logic        dma8_ack = 1'b0, dma16_ack = 1'b0;
    logic [1:0]  mode8, mode16;
    logic        midi_rx_event = 1'b0;
    logic        irq_ack8 = 1'b0, irq_ack16 = 1'b0, irq_ack_midi = 1'b0;
    logic [2:0]  irq_status;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    snd_dsp_sequencer u_snd_dsp_sequencer (.*);

    // {opcode, rate value}
    localparam logic [23:0] RATE_VEC [4] = '{
        {8'h41, 16'd4000}, {8'h42, 16'd44100}, {8'h41, 16'd44100}, {8'h42, 16'd8000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        host_wr_valid = 1'b1;
        host_wr_data  = b;
        @(negedge clk);
        host_wr_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cmd2(input logic [7:0] op, input logic [15:0] v);
        put(op); put(v[15:8]); put(v[7:0]); idle(1);
    endtask

    task automatic start(input logic [7:0] op, input logic [7:0] mode, input logic [15:0] cnt);
        put(op); put(mode); put(cnt[7:0]); put(cnt[15:8]); idle(1);
    endtask

    task automatic acks(input bit wide, input int n);
        for (int i = 0; i < n; i++) begin
            if (wide) dma16_ack = 1'b1; else dma8_ack = 1'b1;
            @(negedge clk);
            dma8_ack = 1'b0;
            dma16_ack = 1'b0;
        end
    endtask

    task automatic clr(input int bitn);
        if (bitn == 0) irq_ack8 = 1'b1;
        if (bitn == 1) irq_ack16 = 1'b1;
        if (bitn == 2) irq_ack_midi = 1'b1;
        @(negedge clk);
        irq_ack8 = 1'b0; irq_ack16 = 1'b0; irq_ack_midi = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] exp_out, exp_in;
        idle(2);
        rst_n = 1'b1;
        idle(1);
        // R10 reset state
        check("R10 busy", host_busy, 0);
        check("R10 req", {dma8_req, dma16_req}, 0);
        check("R10 status", irq_status, 0);
        check("R10 rates", {out_rate, in_rate}, 0);

        // R1 rate table
        exp_out = 16'd0; exp_in = 16'd0;
        for (int i = 0; i < 4; i++) begin
            cmd2(RATE_VEC[i][23:16], RATE_VEC[i][15:0]);
            if (RATE_VEC[i][23:16] == 8'h41) exp_out = RATE_VEC[i][15:0];
            else                             exp_in  = RATE_VEC[i][15:0];
            check("R1 out_rate", out_rate, exp_out);
            check("R1 in_rate", in_rate, exp_in);
        end

        // R7 unknown opcode discarded
        put(8'h77);
        check("R7 no busy on unknown", host_busy, 0);
        cmd2(8'h41, 16'h1234);
        check("R7 next byte is opcode", out_rate, 16'h1234);

        // R6 opcode-valued parameter
        cmd2(8'h41, 16'hC010);
        check("R6 opcode as param", out_rate, 16'hC010);
        check("R6 no engine start", dma8_req, 0);

        // R8 busy cycle drops writes
        put(8'h41); put(8'h56); put(8'h78);
        check("R8 busy after last byte", host_busy, 1);
        put(8'h42);
        check("R8 busy lasts one cycle", host_busy, 0);
        put(8'h11); put(8'h22); idle(1);
        check("R8 dropped byte", in_rate, 16'd8000);
        check("R8 rate applied", out_rate, 16'h5678);

        // R2/R3 8-bit engine, count 3, stereo signed
        start(8'hC0, 8'h03, 16'd3);
        check("R2 mode8", mode8, 2'd3);
        check("R2 req8", dma8_req, 1);
        acks(0, 3);
        check("R3 no end before count+1", irq_status[0], 0);
        acks(0, 1);
        check("R3 block end", irq_status[0], 1);
        check("R5 irq out", irq, 1);
        check("R3 keeps running", dma8_req, 1);
        clr(0);
        check("R5 ack8 clears", irq_status[0], 0);
        acks(0, 3);
        check("R3 reload no end", irq_status[0], 0);
        acks(0, 1);
        check("R3 reload end", irq_status[0], 1);
        clr(0);

        // R2 16-bit engine, count 256 (low byte first)
        start(8'hB0, 8'h01, 16'h0100);
        check("R2 mode16", mode16, 2'd1);
        acks(1, 256);
        check("R2 count low byte first", irq_status[1], 0);
        acks(1, 1);
        check("R3 16-bit end", irq_status, 3'b010);
        clr(0);
        check("R5 other ack ignored", irq_status[1], 1);
        clr(1);
        check("R5 ack16 clears", irq_status[1], 0);

        // R4 pause and resume 8-bit
        acks(0, 2);
        put(8'hD0); idle(1);
        check("R4 paused req", dma8_req, 0);
        check("R4 other engine unaffected", dma16_req, 1);
        acks(0, 5);
        check("R4 acks ignored", irq_status[0], 0);
        put(8'hD4); idle(1);
        check("R4 resumed req", dma8_req, 1);
        acks(0, 1);
        check("R4 count kept", irq_status[0], 0);
        acks(0, 1);
        check("R4 block end after resume", irq_status[0], 1);
        clr(0);

        // R5 MIDI bit
        midi_rx_event = 1'b1; @(negedge clk); midi_rx_event = 1'b0;
        check("R5 midi set", irq_status, 3'b100);
        clr(0);
        check("R5 midi not cleared by ack8", irq_status[2], 1);
        clr(2);
        check("R5 midi cleared", irq_status, 0);

        // R5 event wins over same-cycle ack
        acks(0, 4);
        check("R5 pre", irq_status[0], 1);
        acks(0, 3);
        dma8_ack = 1'b1; irq_ack8 = 1'b1;
        @(negedge clk);
        dma8_ack = 1'b0; irq_ack8 = 1'b0;
        check("R5 set wins", irq_status[0], 1);
        clr(0);

        // R9 start while running takes effect at next boundary
        acks(0, 1);
        start(8'hC0, 8'h00, 16'd1);
        check("R9 mode unchanged mid-block", mode8, 2'd3);
        acks(0, 2);
        check("R9 current block intact", irq_status[0], 0);
        acks(0, 1);
        check("R9 old block ends", irq_status[0], 1);
        clr(0);
        check("R9 new mode", mode8, 2'd0);
        acks(0, 1);
        check("R9 new count not yet", irq_status[0], 0);
        acks(0, 1);
        check("R9 new count block", irq_status[0], 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule